// File: doc/BRIEF.md
# SD Card SPI Byte Master

This block moves single bytes between a processor and an SD card over SPI. The processor reaches it through a small register window with four addresses. Writing a byte to the data address starts an 8-bit full-duplex exchange. Each bit goes out on the serial output while one bit is captured from the card. Reading the data address returns the byte captured by the last finished exchange. A control address holds the card-select level, and a status address shows the engine's busy flag and two card condition pins.

For streaming reads there is a fourth address. A single read there returns the last captured byte and launches the next exchange with an all-ones pattern on the output line. Software can therefore pull a block of data with one access per byte.

The serial clock comes from the system clock divided by an even, parameterized ratio. Exchanges use SPI mode 0, most significant bit first.

Top module: `sd_spi_byte_master`

## Requirements
- R1: After reset, sd_cs_n is 1, sd_sck is 0, busy is 0, sd_mosi is 1 and the data address reads 0x00.
- R2: A write to address 2 (data) while idle starts an exchange that drives the written byte on sd_mosi MSB first. sd_mosi changes only after a falling edge of sd_sck.
- R3: An exchange gives exactly 8 sd_sck pulses. sd_sck idles low, and each pulse is high for CLK_DIV/2 system cycles. busy is high for exactly 8*CLK_DIV system cycles from the edge that accepted the start.
- R4: sd_miso is sampled on each rising edge of sd_sck, MSB first. Once busy falls, a read of address 2 returns the 8 captured bits.
- R5: A read of address 3 (read-and-start) while idle returns the last captured byte in the same cycle and starts an exchange that sends 0xFF.
- R6: A write to address 2 or a read of address 3 while busy is ignored. The running exchange keeps its byte and its length, and the address-3 read still returns the last completed byte.
- R7: Writing address 0 (control) sets sd_cs_n to bit 0 of the written byte on the next cycle. Reading address 0 returns {7'b0, sd_cs_n}.
- R8: Reading address 1 (status) returns bit 0 = busy, bit 1 = card_present, bit 2 = card_locked, and 0 in bits 7:3.
- R9: A read of address 2 has no side effect. It starts no exchange.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data, 3 read-and-start |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; side effects take place on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| card_present | input | 1 | Card-detect level, reported in status bit 1 |
| card_locked | input | 1 | Write-protect level, reported in status bit 2 |
| busy | output | 1 | High while an exchange is running |
| sd_sck | output | 1 | SPI clock, idle low |
| sd_mosi | output | 1 | Serial data to the card |
| sd_miso | input | 1 | Serial data from the card |
| sd_cs_n | output | 1 | Active-low card select |

## Verification
The assertions check the cycle-level rules on every cycle:
- sd_sck stays low whenever the engine is idle.
- sd_mosi holds still except just after a falling clock edge.
- A start attempt made while busy leaves the output line untouched.
- The control write reaches sd_cs_n on the next cycle.
- The status word's layout.
- A plain data read never raises busy.

Some behaviour shows only across a whole exchange, and only the bench's scenarios can show it. This covers the exact bit order seen by a card model, the pulse count and high-time, the total busy length, and the value read back from the card. It also covers whether an ignored start leaves the running exchange's byte intact.

// File: rtl/sd_spi_pkg.sv
package sd_spi_pkg;

    typedef enum logic [1:0] {
        PORT_CTRL = 2'd0,
        PORT_STAT = 2'd1,
        PORT_DATA = 2'd2,
        PORT_RDST = 2'd3
    } port_e;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

    typedef struct packed {
        logic       go;
        logic [7:0] data;
    } start_req_t;

    typedef struct packed {
        logic [4:0] zero;
        logic       locked;
        logic       present;
        logic       busy;
    } status_t;

    function automatic logic [7:0] pack_status(input logic b, input logic p, input logic l);
        status_t s;
        s.zero    = '0;
        s.locked  = l;
        s.present = p;
        s.busy    = b;
        return s;
    endfunction

endpackage

// File: rtl/sd_spi_clkgen.sv
module sd_spi_clkgen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/sd_spi_shifter.sv
module sd_spi_shifter
    import sd_spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  start_req_t req,
    input  logic       tick,
    input  logic       miso,
    output logic       busy,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] last_rx
);
    logic       busy_q;
    logic       sck_q;
    logic [7:0] tx_q;
    logic [7:0] rx_q;
    logic [2:0] bit_q;
    logic [7:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            tx_q   <= FILL_BYTE;
            rx_q   <= '0;
            bit_q  <= '0;
            last_q <= '0;
        end else if (!busy_q && req.go) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            tx_q   <= req.data;
            bit_q  <= '0;
        end else if (busy_q && tick) begin
            sck_q <= !sck_q;
            if (!sck_q) begin
                rx_q <= {rx_q[6:0], miso};
            end else begin
                bit_q <= bit_q + 1'b1;
                if (bit_q == 3'd7) begin
                    busy_q <= 1'b0;
                    last_q <= rx_q;
                    tx_q   <= FILL_BYTE;
                end else begin
                    tx_q <= {tx_q[6:0], 1'b1};
                end
            end
        end
    end

    assign busy    = busy_q;
    assign sck     = sck_q;
    assign mosi    = tx_q[7];
    assign last_rx = last_q;
endmodule

// File: rtl/sd_spi_regs.sv
module sd_spi_regs
    import sd_spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] addr,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       busy,
    input  logic [7:0] last_rx,
    input  logic       present,
    input  logic       locked,
    output logic       cs_n,
    output start_req_t req
);
    port_e sel;
    logic  cs_q;

    assign sel = port_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b1;
        end else if (wr && sel == PORT_CTRL) begin
            cs_q <= wdata[0];
        end
    end

    always_comb begin
        req.go   = 1'b0;
        req.data = FILL_BYTE;
        if (wr && sel == PORT_DATA) begin
            req.go   = 1'b1;
            req.data = wdata;
        end else if (rd && sel == PORT_RDST) begin
            req.go   = 1'b1;
            req.data = FILL_BYTE;
        end
    end

    always_comb begin
        unique case (sel)
            PORT_CTRL: rdata = {7'b0, cs_q};
            PORT_STAT: rdata = pack_status(busy, present, locked);
            PORT_DATA: rdata = last_rx;
            PORT_RDST: rdata = last_rx;
            default:   rdata = '0;
        endcase
    end

    assign cs_n = cs_q;
endmodule

// File: rtl/sd_spi_byte_master.sv
module sd_spi_byte_master
    import sd_spi_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       card_present,
    input  logic       card_locked,
    output logic       busy,
    output logic       sd_sck,
    output logic       sd_mosi,
    input  logic       sd_miso,
    output logic       sd_cs_n
);
    localparam int HALF = CLK_DIV / 2;

    start_req_t req;
    logic       tick;
    logic [7:0] last_rx;

    sd_spi_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .busy    (busy),
        .last_rx (last_rx),
        .present (card_present),
        .locked  (card_locked),
        .cs_n    (sd_cs_n),
        .req     (req)
    );

    sd_spi_clkgen #(.HALF(HALF)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    sd_spi_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .tick    (tick),
        .miso    (sd_miso),
        .busy    (busy),
        .sck     (sd_sck),
        .mosi    (sd_mosi),
        .last_rx (last_rx)
    );
endmodule

// File: rtl/sd_spi_checker.sv
module sd_spi_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       card_present,
    input logic       card_locked,
    input logic       busy,
    input logic       sd_sck,
    input logic       sd_mosi,
    input logic       sd_cs_n
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sd_cs_n && !sd_sck && !busy && sd_mosi));

    a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sd_sck);

    a_r2_mosi_after_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && !sd_sck) |=> (!busy || $stable(sd_mosi)));

    a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && !sd_sck && ((bus_wr && bus_addr == 2'd2) || (bus_rd && bus_addr == 2'd3)))
        |=> $stable(sd_mosi));

    a_r7_cs_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> (sd_cs_n == $past(bus_wdata[0])));

    a_r8_status_layout: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1) |-> (bus_rdata == {5'b0, card_locked, card_present, busy}));

    a_r9_plain_read_no_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_rd && !bus_wr && bus_addr == 2'd2) |=> !busy);
endmodule

bind sd_spi_byte_master sd_spi_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .card_present (card_present),
    .card_locked  (card_locked),
    .busy         (busy),
    .sd_sck       (sd_sck),
    .sd_mosi      (sd_mosi),
    .sd_cs_n      (sd_cs_n)
);

// File: tb/sim_sd_spi_byte_master.sv
`timescale 1ns/1ps
module sim_sd_spi_byte_master;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       card_present = 1'b0;
    logic       card_locked = 1'b0;
    logic       busy, sd_sck, sd_mosi, sd_miso, sd_cs_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] slv_tx = 8'hFF;
    logic [7:0] slv_rx = 8'h00;
    int         pulses = 0;

    always #4 clk = ~clk;

    sd_spi_byte_master #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_present(card_present),
        .card_locked(card_locked), .busy(busy), .sd_sck(sd_sck), .sd_mosi(sd_mosi),
        .sd_miso(sd_miso), .sd_cs_n(sd_cs_n)
    );

    // card model: mode 0, captures on rise, shifts on fall
    assign sd_miso = slv_tx[7];
    always @(posedge sd_sck) begin
        slv_rx <= {slv_rx[6:0], sd_mosi};
        pulses <= pulses + 1;
    end
    always @(negedge sd_sck) slv_tx <= {slv_tx[6:0], 1'b1};

    function automatic int exp_busy_cycles();
        return 8 * DIV;
    endfunction

    function automatic logic [7:0] exp_status(input logic b, input logic p, input logic l);
        return {5'b0, l, p, b};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // counts busy cycles and sck-high cycles until the engine idles
    task automatic wait_idle(output int bcyc, output int hcyc, input bit poke_busy);
        bcyc = 0; hcyc = 0;
        while (busy) begin
            bcyc++;
            if (sd_sck) hcyc++;
            if (poke_busy && bcyc == 5) begin
                bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h00;
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] resp, input bit via_rdst,
                        input logic [7:0] prev, input bit poke);
        int bc, hc;
        logic [7:0] rd;
        slv_tx = resp; pulses = 0;
        if (via_rdst) begin
            bus_read(2'd3, rd);
            check("R5 read-and-start returns previous byte", rd, prev);
        end else begin
            bus_write(2'd2, tx);
        end
        check("R2/R3 busy after start", busy, 1);
        wait_idle(bc, hc, poke);
        check(via_rdst ? "R5 card saw 0xFF" : (poke ? "R6 original byte kept" : "R2 card saw byte MSB first"),
              slv_rx, via_rdst ? 8'hFF : tx);
        check(poke ? "R6 busy length unchanged" : "R3 busy length", bc, exp_busy_cycles());
        check("R3 pulse count", pulses, 8);
        check("R3 sck high time", hc, 8 * HALF);
        check("R1/R2 mosi idles high", sd_mosi, 1);
        bus_read(2'd2, rd);
        check("R4 captured byte", rd, resp);
    endtask

    initial begin
        logic [7:0] rd, prev, t, r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cs_n reset", sd_cs_n, 1);
        check("R1 sck reset", sd_sck, 0);
        check("R1 busy reset", busy, 0);
        check("R1 mosi reset", sd_mosi, 1);
        bus_read(2'd2, rd);
        check("R1 data reset", rd, 8'h00);

        // R7 control register
        bus_write(2'd0, 8'hFE);
        check("R7 cs_n low", sd_cs_n, 0);
        bus_read(2'd0, rd);
        check("R7 control readback", rd, 8'h00);
        bus_write(2'd0, 8'h01);
        bus_read(2'd0, rd);
        check("R7 control readback high", rd, 8'h01);
        check("R7 cs_n high", sd_cs_n, 1);
        bus_write(2'd0, 8'h00);

        // R8 status
        card_present = 1'b1; card_locked = 1'b0;
        bus_read(2'd1, rd);
        check("R8 status present", rd, exp_status(1'b0, 1'b1, 1'b0));
        card_present = 1'b0; card_locked = 1'b1;
        bus_read(2'd1, rd);
        check("R8 status locked", rd, exp_status(1'b0, 1'b0, 1'b1));

        // directed corner bytes
        xfer(8'hA5, 8'h3C, 1'b0, 8'h00, 1'b0);
        xfer(8'h00, 8'hFF, 1'b0, 8'h3C, 1'b0);
        xfer(8'hFF, 8'h01, 1'b0, 8'hFF, 1'b0);
        xfer(8'h80, 8'h80, 1'b0, 8'h01, 1'b0);

        // R9 plain read does not start
        bus_read(2'd2, rd);
        @(negedge clk);
        check("R9 no start on data read", busy, 0);
        check("R9 no sck on data read", pulses, 8);

        // R8 busy bit visible mid-transfer
        slv_tx = 8'h55;
        bus_write(2'd2, 8'h12);
        bus_read(2'd1, rd);
        check("R8 status busy", rd, exp_status(1'b1, 1'b0, 1'b1));
        // R6 read-and-start while busy returns last completed byte
        bus_read(2'd3, rd);
        check("R6 rdst during busy returns last byte", rd, 8'h80);
        while (busy) @(negedge clk);
        check("R6 card saw original byte", slv_rx, 8'h12);
        @(negedge clk);
        check("R6 no restart after rdst during busy", busy, 0);

        // R6 write during busy ignored
        xfer(8'hC3, 8'h96, 1'b0, 8'h55, 1'b1);

        // R5 streaming reads
        prev = 8'h96;
        for (int i = 0; i < 4; i++) begin
            r = 8'($urandom());
            xfer(8'hFF, r, 1'b1, prev, 1'b0);
            prev = r;
        end

        // random traffic
        for (int i = 0; i < 20; i++) begin
            t = 8'($urandom());
            r = 8'($urandom());
            xfer(t, r, 1'b0, prev, 1'b0);
            prev = r;
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule